// File: doc/BRIEF.md
# Cascadable Serial-to-Parallel Column Driver Core

This block is the digital core of a 32-channel display column driver. A host sends a bit stream on a serial data pin and strobes a slow shift clock. Each rising edge of that clock moves the stream one place along a chain of stages. A level-sensitive load input copies the chain into a holding bank. An active-high enable gates the bank onto the parallel channel outputs. The last stage of the chain is brought out on a cascade pin, so several cores can be wired in series and fed from one data line.

The core runs on a faster system clock. Each of the four host inputs passes through its own synchronizer. A shift happens once for each rising edge seen on the synchronized shift clock. The holding bank is a register that reloads on every system cycle while the synchronized load input is high, so it tracks the chain for as long as the load input stays high. A parameter chooses the shift direction.

Top module: `colDrvCore`

## Requirements
- R1: A synchronous active-high reset clears the chain and the holding bank, so every channel output and the cascade output are low after reset, even with load and enable high.
- R2: The chain moves by exactly one place for each low-to-high transition of the shift clock. A high-to-low transition leaves it unchanged.
- R3: With the default forward direction, the serial bit enters stage 1, which is `chanOut[0]`. Earlier bits move one place toward stage 32 (`chanOut[31]`) on each shift.
- R4: The cascade output always shows the final stage. In forward mode that is stage 32, so a bit shifted in shows up there after 32 shifts.
- R5: Shifting goes on whatever the levels of the load and enable inputs are.
- R6: While the load input is high, the holding bank follows the chain, including shifts that happen while the load input stays high.
- R7: While the load input is low, the holding bank keeps its value while new data is shifted in.
- R8: With the enable input low, all channel outputs are low whatever the bank holds. With it high, each channel shows its bank bit.
- R9: With the `REVERSE` parameter set to 1, the serial bit enters stage 32 (`chanOut[31]`), data moves toward stage 1, and the cascade output shows stage 1 (`chanOut[0]`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the shift clock |
| rst | input | 1 | Synchronous active-high reset |
| shiftClk | input | 1 | Host shift clock; a rising edge advances the chain |
| serIn | input | 1 | Serial data bit |
| latchEn | input | 1 | Level-sensitive bank load (high = follow chain) |
| outEn | input | 1 | Channel enable (low = all channels low) |
| chanOut | output | CHANNELS | Parallel channel outputs, bit 0 = stage 1 |
| serOut | output | 1 | Cascade output, final stage of the chain |

## Verification
The assertions assume that the host inputs are slow next to the system clock. Every level has to pass through the synchronizers before the next change arrives, and the serial bit has to be steady when its shift-clock rising edge is seen. The stimulus holds every input level for several system cycles and changes the data bit only while the shift clock is low. Only then does it raise the clock, so no edge is lost and no bit is sampled while it is changing. Both direction variants receive the same stimulus, and each is compared against its own model.

// File: rtl/colDrvPkg.sv
package colDrvPkg;
  // Strobes from the control side to the datapath
  typedef struct packed {
    logic shiftStep;  // one-cycle pulse per detected shift-clock rise
    logic serBit;     // synchronized serial bit
    logic loadBank;   // synchronized level: bank follows chain
    logic outEn;      // synchronized level: channels enabled
  } strobeT;
endpackage

// File: rtl/colDrvSync.sv
module colDrvSync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/colDrvCtrl.sv
module colDrvCtrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shiftClk,
  input  logic              serIn,
  input  logic              latchEn,
  input  logic              outEn,
  output colDrvPkg::strobeT strobes
);
  localparam int IN_COUNT = 4;

  logic [IN_COUNT-1:0] rawIn, syncIn;
  logic prevClk;

  assign rawIn = {shiftClk, serIn, latchEn, outEn};

  colDrvSync #(.WIDTH(IN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rawIn),
    .dout(syncIn)
  );

  always_ff @(posedge clk) begin
    if (rst) prevClk <= 1'b0;
    else     prevClk <= syncIn[3];
  end

  always_comb begin
    strobes.shiftStep = syncIn[3] & ~prevClk;
    strobes.serBit    = syncIn[2];
    strobes.loadBank  = syncIn[1];
    strobes.outEn     = syncIn[0];
  end
endmodule

// File: rtl/colDrvPath.sv
module colDrvPath #(
  parameter int CHANNELS = 32,
  parameter bit REVERSE  = 1'b0
) (
  input  logic                colDrvClk,
  input  logic                rst,
  input  colDrvPkg::strobeT   strobes,
  output logic [CHANNELS-1:0] chanOut,
  output logic                serOut
);
  localparam int LAST = CHANNELS - 1;

  logic [CHANNELS-1:0] chain, chainNext, bank;

  generate
    if (REVERSE) begin : g_rev
      assign chainNext = {strobes.serBit, chain[LAST:1]};
      assign serOut    = chain[0];
    end else begin : g_fwd
      assign chainNext = {chain[LAST-1:0], strobes.serBit};
      assign serOut    = chain[LAST];
    end
  endgenerate

  always_ff @(posedge colDrvClk) begin
    if (rst)                    chain <= '0;
    else if (strobes.shiftStep) chain <= chainNext;
  end

  always_ff @(posedge colDrvClk) begin
    if (rst)                   bank <= '0;
    else if (strobes.loadBank) bank <= chain;
  end

  assign chanOut = strobes.outEn ? bank : '0;
endmodule

// File: rtl/colDrvCore.sv
module colDrvCore #(
  parameter int CHANNELS    = 32,
  parameter int SYNC_STAGES = 2,
  parameter bit REVERSE     = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shiftClk,
  input  logic                serIn,
  input  logic                latchEn,
  input  logic                outEn,
  output logic [CHANNELS-1:0] chanOut,
  output logic                serOut
);
  colDrvPkg::strobeT strobes;

  colDrvCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .shiftClk(shiftClk),
    .serIn   (serIn),
    .latchEn (latchEn),
    .outEn   (outEn),
    .strobes (strobes)
  );

  colDrvPath #(.CHANNELS(CHANNELS), .REVERSE(REVERSE)) u_path (
    .colDrvClk(clk),
    .rst      (rst),
    .strobes  (strobes),
    .chanOut  (chanOut),
    .serOut   (serOut)
  );
endmodule

// File: rtl/colDrvCheck.sv
module colDrvCheck #(
  parameter int CHANNELS = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                shiftStep,
  input logic                loadBank,
  input logic                enSync,
  input logic [CHANNELS-1:0] chanOut,
  input logic                serOut
);
  // R1: one cycle after reset, all outputs are low
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (chanOut == '0 && !serOut));

  // R2: without a detected rising edge, the cascade stage does not move
  assert_no_shift_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !shiftStep |=> $stable(serOut));

  // R7: while loading is off and the channels stay enabled, channels hold
  assert_bank_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!loadBank && enSync) |=> (!enSync || $stable(chanOut)));

  // R8: disabled channels are all low
  assert_gate_low_R8: assert property (@(posedge clk) disable iff (rst)
    !enSync |-> chanOut == '0);
endmodule

bind colDrvCore colDrvCheck #(.CHANNELS(CHANNELS)) u_colDrvCheck (
  .clk      (clk),
  .rst      (rst),
  .shiftStep(strobes.shiftStep),
  .loadBank (strobes.loadBank),
  .enSync   (strobes.outEn),
  .chanOut  (chanOut),
  .serOut   (serOut)
);

// File: tb/test_colDrvCore.sv
module test_colDrvCore;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;
  localparam int SETTLE = 5;

  logic clk = 1'b0;
  logic rst, shiftClk, serIn, latchEn, outEn;
  logic [N-1:0] chanF, chanR;
  logic serF, serR;

  always #(CLK_PERIOD/2) clk = ~clk;

  colDrvCore #(.CHANNELS(N), .REVERSE(1'b0)) i_colDrvCore (
    .clk(clk), .rst(rst), .shiftClk(shiftClk), .serIn(serIn),
    .latchEn(latchEn), .outEn(outEn), .chanOut(chanF), .serOut(serF));

  colDrvCore #(.CHANNELS(N), .REVERSE(1'b1)) i_colDrvCore_rev (
    .clk(clk), .rst(rst), .shiftClk(shiftClk), .serIn(serIn),
    .latchEn(latchEn), .outEn(outEn), .chanOut(chanR), .serOut(serR));

  typedef struct {
    string        tag;
    logic [N-1:0] expF;
    logic         expSerF;
    logic [N-1:0] expR;
    logic         expSerR;
  } itemT;

  itemT queue[$];
  int compared = 0;
  int mismatched = 0;

  // reference model, built from the requirements
  logic [N-1:0] mChainF = '0, mChainR = '0, mBankF = '0, mBankR = '0;
  logic mLe = 1'b0, mOe = 1'b0;

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic push(input string tag);
    itemT it;
    it.tag = tag;
    it.expF = mOe ? mBankF : '0;
    it.expR = mOe ? mBankR : '0;
    it.expSerF = mChainF[N-1];
    it.expSerR = mChainR[0];
    queue.push_back(it);
    @(negedge clk);
  endtask

  task automatic shiftBit(input logic b);
    serIn = b; shiftClk = 1'b0; settle();
    shiftClk = 1'b1; settle();
    mChainF = {mChainF[N-2:0], b};
    mChainR = {b, mChainR[N-1:1]};
    if (mLe) begin mBankF = mChainF; mBankR = mChainR; end
  endtask

  task automatic fallOnly(input logic b);
    serIn = b; shiftClk = 1'b0; settle();
  endtask

  task automatic setLe(input logic v);
    latchEn = v; mLe = v; settle();
    if (v) begin mBankF = mChainF; mBankR = mChainR; end
  endtask

  task automatic setOe(input logic v);
    outEn = v; mOe = v; settle();
  endtask

  // monitor: pops expected items and compares them
  initial begin
    itemT it;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      while (queue.size() > 0) begin
        it = queue.pop_front();
        compared += 4;
        if (chanF !== it.expF) begin
          mismatched++;
          $display("FAIL %s fwd chanOut actual=%h expected=%h", it.tag, chanF, it.expF);
        end
        if (serF !== it.expSerF) begin
          mismatched++;
          $display("FAIL %s fwd serOut actual=%b expected=%b", it.tag, serF, it.expSerF);
        end
        if (chanR !== it.expR) begin
          mismatched++;
          $display("FAIL R9 (%s) rev chanOut actual=%h expected=%h", it.tag, chanR, it.expR);
        end
        if (serR !== it.expSerR) begin
          mismatched++;
          $display("FAIL R9 (%s) rev serOut actual=%b expected=%b", it.tag, serR, it.expSerR);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  // driver
  initial begin
    logic [N-1:0] pat;
    rst = 1'b1; shiftClk = 1'b0; serIn = 1'b0; latchEn = 1'b0; outEn = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle();
    push("R1 reset state");
    setOe(1'b1); setLe(1'b1);
    push("R1 zeros with load and enable high");

    // R3/R6: bank follows chain while load is high
    shiftBit(1'b1); push("R3 first bit at stage 1");
    shiftBit(1'b0); push("R3 bit moves toward stage 32");
    shiftBit(1'b1); push("R6 bank tracks shift");
    shiftBit(1'b1); push("R6 bank tracks shift");

    // R2: falling edge alone does nothing
    fallOnly(1'b0); push("R2 falling edge no shift");
    shiftBit(1'b0); push("R2 rising edge one shift");

    // R7: hold with load low
    setLe(1'b0);
    shiftBit(1'b1); shiftBit(1'b1); shiftBit(1'b0);
    push("R7 bank holds while shifting");

    // R5/R8: shift a full word with load low and channels disabled
    setOe(1'b0);
    pat = 32'hA5C3_0F96;
    for (int i = 0; i < N; i++) begin
      shiftBit(pat[i]);
      if (i == 7) push("R8 disabled channels low");
    end
    push("R4 cascade shows last stage after full word");
    setOe(1'b1); push("R8 enable shows held bank");
    setLe(1'b1); push("R5 full word shifted with load low");
    shiftBit(1'b0); push("R4 cascade after one more shift");
    setOe(1'b0); shiftBit(1'b1); push("R5 shift while disabled");
    setOe(1'b1); push("R8 re-enable shows bank");

    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule